// File: doc/BRIEF.md
# Host-Side Byte FIFO Pair with Watermarks and Clock Stall

This block holds the data that travels between a host register/DMA port and a flash data shifter. It contains a transmit FIFO, which the host fills with 32-bit words and the shifter drains one byte per strobe. It also contains a receive FIFO, which the shifter fills one byte per strobe and the host drains as 32-bit words. Each FIFO reports its occupancy in whole 8-byte entries. Each FIFO compares its level with a programmable watermark to produce a flag, and the flag becomes a DMA request when that FIFO's request enable is set.

While the serial engine is in a write phase and the transmit FIFO has nothing left, the block asks the serial clock generator to pause. It does the same while the engine is in a read phase and the receive FIFO has no room. In both cases no byte is lost or invented. Each kind of stall also leaves a sticky flag that stays set until it is written off. Each FIFO can be emptied at once by a one-cycle clear pulse.

Top module: `host_data_fifo`

## Requirements
- R1: After reset, with both request enables low, both fill outputs are 0. The TX watermark flag is 1 and the RX watermark flag is 0. Both DMA requests, the clock-stop output and both sticky stall flags are 0.
- R2: The bytes of a 32-bit host word leave through the TX byte output lowest byte first (bits 7:0 first, bits 31:24 last). The output always shows the oldest byte that has not been sent.
- R3: Four received bytes make one host word, and the first byte received lands in bits 7:0. The host read data shows the oldest complete word while at least 4 bytes are stored.
- R4: Each fill output equals the FIFO's byte count divided by 8, rounded down. The capacity is ENTRIES × 8 bytes.
- R5: The TX watermark flag is 1 exactly when floor(free bytes / 8) ≥ TX level + 1. The TX DMA request is that flag ANDed with the TX request enable.
- R6: The RX watermark flag is 1 exactly when floor(stored bytes / 8) ≥ RX level + 1. The RX DMA request is that flag ANDed with the RX request enable.
- R7: A clear pulse empties its FIFO by the next cycle. It overrides any push or pop in the same cycle, and later data comes out starting from the next word written.
- R8: The block ignores transfers it cannot complete, and the stored data is left unchanged. These are a host write with fewer than 4 free bytes, a received byte while RX is full, a shift strobe while TX is empty, and a host read with fewer than 4 stored bytes.
- R9: The clock-stop output rises one cycle after a write phase meets an empty TX FIFO, or after a read phase meets a full RX FIFO. It falls one cycle after that condition ends.
- R10: The sticky stall flags set together with the stall they record. Bit 0 of the sticky-clear input clears the TX-empty flag and bit 1 clears the RX-full flag. A stall that is still present in the same cycle keeps its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostTxWrite | input | 1 | Host pushes one word into TX |
| hostTxData | input | 32 | Word to push, low byte sent first |
| hostRxRead | input | 1 | Host pops one word from RX |
| hostRxData | output | 32 | Oldest complete RX word |
| txByteStrobe | input | 1 | Shifter takes one TX byte |
| txByte | output | 8 | Oldest unsent TX byte |
| rxByteStrobe | input | 1 | Shifter delivers one RX byte |
| rxByte | input | 8 | Received byte |
| writePhase | input | 1 | Serial engine is sending data |
| readPhase | input | 1 | Serial engine is receiving data |
| txWmLevel | input | $clog2(ENTRIES) | TX watermark, value N means N+1 entries |
| rxWmLevel | input | $clog2(ENTRIES) | RX watermark, value N means N+1 entries |
| txDmaEn | input | 1 | TX DMA request enable |
| rxDmaEn | input | 1 | RX DMA request enable |
| txClear | input | 1 | Empty the TX FIFO |
| rxClear | input | 1 | Empty the RX FIFO |
| stickyClear | input | 2 | Write-one-to-clear for sticky flags (bit 0 TX, bit 1 RX) |
| txFill | output | $clog2(ENTRIES+1) | TX fill in 8-byte entries |
| rxFill | output | $clog2(ENTRIES+1) | RX fill in 8-byte entries |
| txWmFlag | output | 1 | TX free space at or above watermark |
| rxWmFlag | output | 1 | RX data at or above watermark |
| txDmaReq | output | 1 | TX DMA request |
| rxDmaReq | output | 1 | RX DMA request |
| sckStop | output | 1 | Pause request to the serial clock |
| stopByTxEmpty | output | 1 | Sticky: stalled on empty TX |
| stopByRxFull | output | 1 | Sticky: stalled on full RX |

## Verification
The bench fills TX to its last free word and then writes once more. A design that accepted that write would overwrite unsent bytes, and the scoreboard would see the wrong byte sequence. The bench also drives a shift strobe on an empty TX, a host read from an RX holding fewer than 4 bytes, and a received byte into a full RX; in each case the stream that follows must be unchanged. It sweeps the fill and watermark flags through partial 8-byte entries, where a design that rounded up or counted words instead of entries would report the wrong fill or raise its flags early. It times the clock-stop edges and the sticky flags, including a clear issued while the stall is still present. A design that cleared the flag in that case, or released the stop a cycle early or late, fails those checks.

// File: rtl/hdf_pkg.sv
package hdf_pkg;
  // Per-cycle commands from the control to the storage rings.
  typedef struct packed {
    logic txPushWord;
    logic txPopByte;
    logic txFlush;
    logic rxPushByte;
    logic rxPopWord;
    logic rxFlush;
  } fifoStrobes_t;
endpackage

// File: rtl/hdf_ring.sv
// Byte-addressed circular store. IN_W/OUT_W select a word or byte side.
module hdf_ring #(
  parameter int DEPTH_BYTES = 32,
  parameter bit WORD_IN     = 1'b1,
  localparam int IN_W  = WORD_IN ? 32 : 8,
  localparam int OUT_W = WORD_IN ? 8 : 32,
  localparam int CNT_W = $clog2(DEPTH_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [IN_W-1:0]  dataIn,
  output logic [OUT_W-1:0] dataOut,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W  = $clog2(DEPTH_BYTES);
  localparam int PUSH_N = IN_W / 8;
  localparam int POP_N  = OUT_W / 8;

  logic [7:0]       mem [DEPTH_BYTES];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      for (int k = 0; k < PUSH_N; k++) begin
        mem[wrPtr + PTR_W'(k)] <= dataIn[8*k +: 8];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < POP_N; k++) begin
      dataOut[8*k +: 8] = mem[rdPtr + PTR_W'(k)];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + PTR_W'(PUSH_N);
      if (pop)  rdPtr <= rdPtr + PTR_W'(POP_N);
      count <= count + (push ? CNT_W'(PUSH_N) : CNT_W'(0))
                     - (pop  ? CNT_W'(POP_N)  : CNT_W'(0));
    end
  end

  // R7: a flush leaves the ring empty.
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
  // R8: the control never asks for more room or data than exists.
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (push && !flush) |-> (int'(count) + PUSH_N - (pop ? POP_N : 0) <= DEPTH_BYTES));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !flush) |-> (int'(count) >= POP_N));
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(count) <= DEPTH_BYTES);
endmodule

// File: rtl/hdf_datapath.sv
module hdf_datapath
  import hdf_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int CAP   = ENTRIES * 8,
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  input  logic [31:0]      hostTxData,
  input  logic [7:0]       rxByte,
  output logic [7:0]       txByte,
  output logic [31:0]      hostRxData,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount
);
  hdf_ring #(.DEPTH_BYTES(CAP), .WORD_IN(1'b1)) u_txRing (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (strobes.txFlush),
    .push   (strobes.txPushWord),
    .pop    (strobes.txPopByte),
    .dataIn (hostTxData),
    .dataOut(txByte),
    .count  (txCount)
  );

  hdf_ring #(.DEPTH_BYTES(CAP), .WORD_IN(1'b0)) u_rxRing (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (strobes.rxFlush),
    .push   (strobes.rxPushByte),
    .pop    (strobes.rxPopWord),
    .dataIn (rxByte),
    .dataOut(hostRxData),
    .count  (rxCount)
  );
endmodule

// File: rtl/hdf_control.sv
module hdf_control
  import hdf_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int CAP   = ENTRIES * 8,
  localparam int CNT_W = $clog2(CAP + 1),
  localparam int ENT_W = $clog2(ENTRIES + 1),
  localparam int WM_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             hostTxWrite,
  input  logic             hostRxRead,
  input  logic             txByteStrobe,
  input  logic             rxByteStrobe,
  input  logic             writePhase,
  input  logic             readPhase,
  input  logic [WM_W-1:0]  txWmLevel,
  input  logic [WM_W-1:0]  rxWmLevel,
  input  logic             txDmaEn,
  input  logic             rxDmaEn,
  input  logic             txClear,
  input  logic             rxClear,
  input  logic [1:0]       stickyClear,
  output fifoStrobes_t     strobes,
  output logic [ENT_W-1:0] txFill,
  output logic [ENT_W-1:0] rxFill,
  output logic             txWmFlag,
  output logic             rxWmFlag,
  output logic             txDmaReq,
  output logic             rxDmaReq,
  output logic             sckStop,
  output logic             stopByTxEmpty,
  output logic             stopByRxFull
);
  logic [CNT_W-1:0] txFree;
  logic [ENT_W-1:0] txFreeEnt;
  logic             txEmpty;
  logic             rxFull;
  logic             txStallCond;
  logic             rxStallCond;

  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount == CNT_W'(CAP));

  // Accept only what can complete; a clear overrides everything.
  always_comb begin
    strobes.txFlush    = txClear;
    strobes.rxFlush    = rxClear;
    strobes.txPushWord = hostTxWrite && !txClear && (txCount <= CNT_W'(CAP - 4));
    strobes.txPopByte  = txByteStrobe && !txClear && !txEmpty;
    strobes.rxPushByte = rxByteStrobe && !rxClear && !rxFull;
    strobes.rxPopWord  = hostRxRead && !rxClear && (rxCount >= CNT_W'(4));
  end

  // Levels in whole 8-byte entries.
  assign txFree    = CNT_W'(CAP) - txCount;
  assign txFreeEnt = ENT_W'(txFree >> 3);
  assign txFill    = ENT_W'(txCount >> 3);
  assign rxFill    = ENT_W'(rxCount >> 3);

  assign txWmFlag = txFreeEnt >= (ENT_W'(txWmLevel) + ENT_W'(1));
  assign rxWmFlag = rxFill    >= (ENT_W'(rxWmLevel) + ENT_W'(1));
  assign txDmaReq = txWmFlag && txDmaEn;
  assign rxDmaReq = rxWmFlag && rxDmaEn;

  assign txStallCond = writePhase && txEmpty;
  assign rxStallCond = readPhase && rxFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckStop       <= 1'b0;
      stopByTxEmpty <= 1'b0;
      stopByRxFull  <= 1'b0;
    end else begin
      sckStop       <= txStallCond || rxStallCond;
      stopByTxEmpty <= txStallCond || (stopByTxEmpty && !stickyClear[0]);
      stopByRxFull  <= rxStallCond || (stopByRxFull && !stickyClear[1]);
    end
  end

  // R9: stop follows the stall condition by exactly one cycle.
  assert_stall_raise_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((writePhase && txCount == '0) || (readPhase && rxCount == CNT_W'(CAP))) |=> sckStop);
  assert_stall_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    !((writePhase && txCount == '0) || (readPhase && rxCount == CNT_W'(CAP))) |=> !sckStop);
  // R10: sticky flags hold until written off.
  assert_sticky_tx_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stopByTxEmpty && !stickyClear[0]) |=> stopByTxEmpty);
  assert_sticky_rx_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stopByRxFull && !stickyClear[1]) |=> stopByRxFull);
  // R8: the RX side does not accept a byte into a full ring.
  assert_rx_full_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxByteStrobe && rxFull && !rxClear && !hostRxRead) |=> $stable(rxCount));
endmodule

// File: rtl/host_data_fifo.sv
module host_data_fifo
  import hdf_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int ENT_W = $clog2(ENTRIES + 1),
  localparam int WM_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostTxWrite,
  input  logic [31:0]      hostTxData,
  input  logic             hostRxRead,
  output logic [31:0]      hostRxData,
  input  logic             txByteStrobe,
  output logic [7:0]       txByte,
  input  logic             rxByteStrobe,
  input  logic [7:0]       rxByte,
  input  logic             writePhase,
  input  logic             readPhase,
  input  logic [WM_W-1:0]  txWmLevel,
  input  logic [WM_W-1:0]  rxWmLevel,
  input  logic             txDmaEn,
  input  logic             rxDmaEn,
  input  logic             txClear,
  input  logic             rxClear,
  input  logic [1:0]       stickyClear,
  output logic [ENT_W-1:0] txFill,
  output logic [ENT_W-1:0] rxFill,
  output logic             txWmFlag,
  output logic             rxWmFlag,
  output logic             txDmaReq,
  output logic             rxDmaReq,
  output logic             sckStop,
  output logic             stopByTxEmpty,
  output logic             stopByRxFull
);
  localparam int CNT_W = $clog2(ENTRIES * 8 + 1);

  fifoStrobes_t     strobes;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;

  hdf_control #(.ENTRIES(ENTRIES)) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .txCount      (txCount),
    .rxCount      (rxCount),
    .hostTxWrite  (hostTxWrite),
    .hostRxRead   (hostRxRead),
    .txByteStrobe (txByteStrobe),
    .rxByteStrobe (rxByteStrobe),
    .writePhase   (writePhase),
    .readPhase    (readPhase),
    .txWmLevel    (txWmLevel),
    .rxWmLevel    (rxWmLevel),
    .txDmaEn      (txDmaEn),
    .rxDmaEn      (rxDmaEn),
    .txClear      (txClear),
    .rxClear      (rxClear),
    .stickyClear  (stickyClear),
    .strobes      (strobes),
    .txFill       (txFill),
    .rxFill       (rxFill),
    .txWmFlag     (txWmFlag),
    .rxWmFlag     (rxWmFlag),
    .txDmaReq     (txDmaReq),
    .rxDmaReq     (rxDmaReq),
    .sckStop      (sckStop),
    .stopByTxEmpty(stopByTxEmpty),
    .stopByRxFull (stopByRxFull)
  );

  hdf_datapath #(.ENTRIES(ENTRIES)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hostTxData(hostTxData),
    .rxByte    (rxByte),
    .txByte    (txByte),
    .hostRxData(hostRxData),
    .txCount   (txCount),
    .rxCount   (rxCount)
  );
endmodule

// File: tb/host_data_fifo_tb.sv
module host_data_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 4;
  localparam int CAP = ENTRIES * 8;
  localparam int ENT_W = $clog2(ENTRIES + 1);
  localparam int WM_W = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostTxWrite = 1'b0;
  logic [31:0] hostTxData = '0;
  logic hostRxRead = 1'b0;
  logic [31:0] hostRxData;
  logic txByteStrobe = 1'b0;
  logic [7:0] txByte;
  logic rxByteStrobe = 1'b0;
  logic [7:0] rxByte = '0;
  logic writePhase = 1'b0;
  logic readPhase = 1'b0;
  logic [WM_W-1:0] txWmLevel = '0;
  logic [WM_W-1:0] rxWmLevel = '0;
  logic txDmaEn = 1'b0;
  logic rxDmaEn = 1'b0;
  logic txClear = 1'b0;
  logic rxClear = 1'b0;
  logic [1:0] stickyClear = '0;
  logic [ENT_W-1:0] txFill;
  logic [ENT_W-1:0] rxFill;
  logic txWmFlag, rxWmFlag, txDmaReq, rxDmaReq;
  logic sckStop, stopByTxEmpty, stopByRxFull;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  host_data_fifo #(.ENTRIES(ENTRIES)) u_dut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver side: model accepts the word only if 4 bytes are free.
  task automatic hostWrite(input logic [31:0] w);
    if (txQ.size() <= CAP - 4)
      for (int k = 0; k < 4; k++) txQ.push_back(w[8*k +: 8]);
    hostTxWrite = 1'b1;
    hostTxData = w;
    tick();
    hostTxWrite = 1'b0;
  endtask

  // Monitor side: compare the presented byte with the scoreboard head.
  task automatic shiftOut();
    logic [7:0] e;
    if (txQ.size() > 0) begin
      e = txQ.pop_front();
      checkEq("R2 tx byte order", {24'h0, txByte}, {24'h0, e});
    end
    txByteStrobe = 1'b1;
    tick();
    txByteStrobe = 1'b0;
  endtask

  task automatic shiftIn(input logic [7:0] b);
    if (rxQ.size() < CAP) rxQ.push_back(b);
    rxByteStrobe = 1'b1;
    rxByte = b;
    tick();
    rxByteStrobe = 1'b0;
  endtask

  task automatic hostRead();
    logic [31:0] e;
    if (rxQ.size() >= 4) begin
      for (int k = 0; k < 4; k++) e[8*k +: 8] = rxQ.pop_front();
      checkEq("R3 rx word assembly", hostRxData, e);
    end
    hostRxRead = 1'b1;
    tick();
    hostRxRead = 1'b0;
  endtask

  task automatic checkLevels(input string tag);
    logic expTx, expRx;
    expTx = ((CAP - txQ.size()) / 8) >= (int'(txWmLevel) + 1);
    expRx = (rxQ.size() / 8) >= (int'(rxWmLevel) + 1);
    checkEq({"R4 tx fill ", tag}, 32'(txFill), 32'(txQ.size() / 8));
    checkEq({"R4 rx fill ", tag}, 32'(rxFill), 32'(rxQ.size() / 8));
    checkEq({"R5 tx wm flag ", tag}, 32'(txWmFlag), 32'(expTx));
    checkEq({"R5 tx dma req ", tag}, 32'(txDmaReq), 32'(expTx & txDmaEn));
    checkEq({"R6 rx wm flag ", tag}, 32'(rxWmFlag), 32'(expRx));
    checkEq({"R6 rx dma req ", tag}, 32'(rxDmaReq), 32'(expRx & rxDmaEn));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();

    // R1 reset state
    checkEq("R1 tx fill", 32'(txFill), 0);
    checkEq("R1 rx fill", 32'(rxFill), 0);
    checkEq("R1 tx wm flag", 32'(txWmFlag), 1);
    checkEq("R1 rx wm flag", 32'(rxWmFlag), 0);
    checkEq("R1 dma reqs", {30'h0, txDmaReq, rxDmaReq}, 0);
    checkEq("R1 stall outputs", {29'h0, sckStop, stopByTxEmpty, stopByRxFull}, 0);

    // R4/R5 partial entries and TX watermark
    txWmLevel = 2'd3;
    txDmaEn = 1'b1;
    hostWrite(32'h44332211);
    checkLevels("4B");
    hostWrite(32'h88776655);
    checkLevels("8B");
    hostWrite(32'hCCBBAA99);
    checkLevels("12B");
    txWmLevel = 2'd1;
    #1 checkLevels("12B wm1");
    hostWrite(32'h00FFEEDD);
    hostWrite(32'h04030201);
    checkLevels("20B wm1");
    for (int i = 0; i < 20; i++) shiftOut();
    checkLevels("drained");

    // R8 TX overflow and underflow
    for (int i = 0; i < 8; i++) hostWrite(32'hA0A0A000 + 32'(i));
    checkLevels("tx full");
    hostWrite(32'hDEADBEEF);
    checkEq("R8 tx write when full dropped", 32'(txFill), 4);
    for (int i = 0; i < 32; i++) shiftOut();
    txByteStrobe = 1'b1;
    tick();
    txByteStrobe = 1'b0;
    checkEq("R8 tx strobe when empty", 32'(txFill), 0);
    hostWrite(32'h5A5A5A11);
    shiftOut();
    shiftOut();
    shiftOut();
    shiftOut();

    // R9/R10 TX-empty stall
    writePhase = 1'b1;
    checkEq("R9 stop not yet", 32'(sckStop), 0);
    tick();
    checkEq("R9 stop after tx empty", 32'(sckStop), 1);
    checkEq("R10 tx sticky set", 32'(stopByTxEmpty), 1);
    hostWrite(32'h13121110);
    checkEq("R9 stop held one cycle", 32'(sckStop), 1);
    tick();
    checkEq("R9 stop released", 32'(sckStop), 0);
    checkEq("R10 tx sticky held", 32'(stopByTxEmpty), 1);
    stickyClear = 2'b01;
    tick();
    stickyClear = 2'b00;
    checkEq("R10 tx sticky cleared", 32'(stopByTxEmpty), 0);
    for (int i = 0; i < 4; i++) shiftOut();
    tick();
    stickyClear = 2'b01;
    tick();
    stickyClear = 2'b00;
    checkEq("R10 set wins over clear", 32'(stopByTxEmpty), 1);
    writePhase = 1'b0;
    stickyClear = 2'b01;
    tick();
    stickyClear = 2'b00;
    checkEq("R10 tx sticky off", 32'(stopByTxEmpty), 0);
    checkEq("R9 stop off", 32'(sckStop), 0);

    // R3/R6 RX assembly and watermark
    rxWmLevel = 2'd0;
    rxDmaEn = 1'b1;
    for (int i = 0; i < 5; i++) shiftIn(8'h30 + 8'(i));
    checkLevels("rx 5B");
    for (int i = 5; i < 8; i++) shiftIn(8'h30 + 8'(i));
    checkLevels("rx 8B");
    hostRead();
    hostRead();
    checkLevels("rx empty");
    hostRead();
    checkEq("R8 rx read when short", 32'(rxFill), 0);
    for (int i = 0; i < 4; i++) shiftIn(8'h70 + 8'(i));
    hostRead();

    // R9/R10/R8 RX-full stall
    for (int i = 0; i < 32; i++) shiftIn(8'(i * 7 + 1));
    rxWmLevel = 2'd3;
    #1 checkLevels("rx full");
    readPhase = 1'b1;
    tick();
    checkEq("R9 stop after rx full", 32'(sckStop), 1);
    checkEq("R10 rx sticky set", 32'(stopByRxFull), 1);
    shiftIn(8'hEE);
    checkEq("R8 rx byte when full dropped", 32'(rxFill), 4);
    readPhase = 1'b0;
    tick();
    checkEq("R9 rx stop released", 32'(sckStop), 0);
    for (int i = 0; i < 8; i++) hostRead();
    checkEq("R10 rx sticky held", 32'(stopByRxFull), 1);
    stickyClear = 2'b10;
    tick();
    stickyClear = 2'b00;
    checkEq("R10 rx sticky cleared", 32'(stopByRxFull), 0);

    // R7 clears override same-cycle traffic
    hostWrite(32'h11111111);
    hostWrite(32'h22222222);
    txClear = 1'b1;
    hostTxWrite = 1'b1;
    hostTxData = 32'h33333333;
    tick();
    txClear = 1'b0;
    hostTxWrite = 1'b0;
    txQ.delete();
    checkEq("R7 tx cleared", 32'(txFill), 0);
    hostWrite(32'hC3C2C1C0);
    for (int i = 0; i < 4; i++) shiftOut();
    checkEq("R7 tx empty after drain", 32'(txFill), 0);
    for (int i = 0; i < 8; i++) shiftIn(8'h90 + 8'(i));
    rxClear = 1'b1;
    rxByteStrobe = 1'b1;
    rxByte = 8'h55;
    tick();
    rxClear = 1'b0;
    rxByteStrobe = 1'b0;
    rxQ.delete();
    checkEq("R7 rx cleared", 32'(rxFill), 0);
    for (int i = 0; i < 4; i++) shiftIn(8'hB0 + 8'(i));
    hostRead();
    checkLevels("final");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule